// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel working in waveform mode. A single up-counter, shared by two outputs, steps on a selectable clock tick and returns to zero when it equals the period register. Each output flop changes level in response to three kinds of event: a software trigger, the counter reaching the period value, and the counter reaching that output's own compare value. The response to each event (hold, set, clear, toggle) is programmed in a mode register. Output A uses compare register A, and output B uses compare register B. Both share the period register.

Software writes the mode, the compare registers and the period register through a simple synchronous write port, and reads them back through a one-cycle read port. A write-only command word starts the clock, stops it, or fires a software trigger. The software trigger restarts the count and applies each output's trigger action at once. For ordinary PWM, an output is set on the period match and cleared on its compare match (normal polarity), or the other way round (inverted polarity). If an output's compare actions are left at hold, it keeps the static level that the last trigger gave it.

Top module: `tmr_wave_channel`

## Requirements
- R1: While reset is high, out_a, out_b, the counter, the run state, rd_data and all registers go to zero. They stay there until the first write after reset.
- R2: A write with wr_en high updates the register at wr_addr on the next edge: 0 = mode (low 16 bits), 1 = compare A, 2 = compare B, 3 = period. rd_data shows, one edge later, the register selected by rd_addr. Address 4 reads the counter, and addresses 5 to 7 read zero.
- R3: Mode bits [2:0] pick the counting tick. Codes 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 cycles of a free-running prescaler. Codes 4 to 7 use the slow_tick strobe input.
- R4: While running, the counter rises by one on each tick. On the tick where it equals the period register it becomes zero instead.
- R5: Actions are 2-bit codes: 0 hold, 1 set, 2 clear, 3 toggle. Output A takes its compare action from mode [5:4], its period action from [7:6] and its trigger action from [9:8]. Output B takes the same three actions from [11:10], [13:12] and [15:14]. A compare or period event counts only on a running tick, and only when the counter value before that tick matches.
- R6: When several events reach one output in the same cycle, only the highest applies. The software trigger comes first, then the period match, then the compare match. A winning event whose action is hold still blocks the events below it.
- R7: Writing address 4 with bit 2 set clears the counter and the prescaler on the next edge. On that same edge each output applies its trigger action.
- R8: Writing address 4 with bit 0 set starts the clock, and with bit 1 set stops it. If both bits are set, stop wins. While stopped, the counter and both outputs keep their values unless a trigger arrives.
- R9: With mode bit 3 clear, both outputs are driven low on every edge and all actions are ignored.
- R10: Writes to the compare and period registers are accepted at any time and have no shadow copy. The first tick after the write compares against the new value.
- R11: With period action set and compare action clear, an output is high from the period match until its compare match (normal polarity). If both compare-side actions are hold, the output keeps the level from the last trigger for as long as no other trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | CNT_W | Registered read data |
| slow_tick | input | 1 | One-cycle slow clock strobe used by tick codes 4 to 7 |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The bench uses the default CNT_W of 16 and ADDR_W of 3. It keeps random period and compare values below 24, so the counter wraps many times per run. Compare and period matches often fall on the same tick, which exercises the priority order, and period writes below the current count push the counter through its full 16-bit wrap. The slow_tick strobe is driven randomly by the bench, so tick codes 4 to 7 are reached alongside all four prescaler divisions.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_FLIP = 2'd3
  } edge_act_e;

  localparam int MODE_W      = 16;
  localparam int SEL_W       = 3;
  localparam int WAVE_BIT    = 3;
  localparam int LANE_BASE   = 4;
  localparam int LANE_STRIDE = 6;
  localparam int NUM_LANES   = 2;

  localparam int ADDR_MODE = 0;
  localparam int ADDR_CMPA = 1;
  localparam int ADDR_CMPB = 2;
  localparam int ADDR_PER  = 3;
  localparam int ADDR_CMD  = 4;

  localparam int CMD_RUN  = 0;
  localparam int CMD_STOP = 1;
  localparam int CMD_TRIG = 2;

  function automatic logic next_level(logic cur, edge_act_e a);
    logic r;
    unique case (a)
      ACT_SET:  r = 1'b1;
      ACT_CLR:  r = 1'b0;
      ACT_FLIP: r = ~cur;
      default:  r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_wave_prescale.sv
module tmr_wave_prescale
  import tmr_wave_pkg::*;
#(
  parameter int NUM_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);
  localparam int PRE_W = 2 * NUM_DIV - 1;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] div_tick;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  // division by 2, 8, 32, 128 ... : all low bits of the prescaler set
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam int MW = 2 * g + 1;
    assign div_tick[g] = &pre_q[MW-1:0];
  end

  always_comb begin
    tick = slow_tick;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (sel == SEL_W'(i)) tick = div_tick[i];
    end
  end
endmodule

// File: rtl/tmr_wave_lane.sv
module tmr_wave_lane
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wave,
  input  logic             trig,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] cmp,
  input  edge_act_e        act_trig,
  input  edge_act_e        act_per,
  input  edge_act_e        act_cmp,
  output logic             out_q
);
  edge_act_e act;

  // fixed priority: trigger, period match, compare match
  always_comb begin
    act = ACT_HOLD;
    if (trig)                     act = act_trig;
    else if (step && cnt == per)  act = act_per;
    else if (step && cnt == cmp)  act = act_cmp;
  end

  always_ff @(posedge clk) begin
    if (rst || !wave) out_q <= 1'b0;
    else              out_q <= next_level(out_q, act);
  end
endmodule

// File: rtl/tmr_wave_channel.sv
module tmr_wave_channel
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              slow_tick,
  output logic              out_a,
  output logic              out_b
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cmp_q [NUM_LANES];
  logic [CNT_W-1:0]  per_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              tick;
  logic              step;
  logic              wave_on;
  logic              cmd_wr, trig_fire, run_req, stop_req;
  logic [NUM_LANES-1:0] lane_out;

  assign cmd_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));
  assign trig_fire = cmd_wr && wr_data[CMD_TRIG];
  assign run_req   = cmd_wr && wr_data[CMD_RUN];
  assign stop_req  = cmd_wr && wr_data[CMD_STOP];
  assign wave_on   = mode_q[WAVE_BIT];
  assign step      = run_q && tick;

  tmr_wave_prescale #(.NUM_DIV(4)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .restart   (trig_fire),
    .sel       (mode_q[SEL_W-1:0]),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  // run state: stop dominates start
  always_ff @(posedge clk) begin
    if (rst)           run_q <= 1'b0;
    else if (stop_req) run_q <= 1'b0;
    else if (run_req)  run_q <= 1'b1;
  end

  // up-counter with automatic return to zero on the period match
  always_ff @(posedge clk) begin
    if (rst || trig_fire) cnt_q <= '0;
    else if (step)        cnt_q <= (cnt_q == per_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      per_q  <= '0;
      for (int i = 0; i < NUM_LANES; i++) cmp_q[i] <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_W'(ADDR_MODE): mode_q   <= wr_data[MODE_W-1:0];
        ADDR_W'(ADDR_CMPA): cmp_q[0] <= wr_data;
        ADDR_W'(ADDR_CMPB): cmp_q[1] <= wr_data;
        ADDR_W'(ADDR_PER):  per_q    <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        ADDR_W'(ADDR_MODE): rd_data <= CNT_W'(mode_q);
        ADDR_W'(ADDR_CMPA): rd_data <= cmp_q[0];
        ADDR_W'(ADDR_CMPB): rd_data <= cmp_q[1];
        ADDR_W'(ADDR_PER):  rd_data <= per_q;
        ADDR_W'(ADDR_CMD):  rd_data <= cnt_q;
        default:            rd_data <= '0;
      endcase
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam int B = LANE_BASE + LANE_STRIDE * l;
    tmr_wave_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .wave     (wave_on),
      .trig     (trig_fire),
      .step     (step),
      .cnt      (cnt_q),
      .per      (per_q),
      .cmp      (cmp_q[l]),
      .act_trig (edge_act_e'(mode_q[B+4 +: 2])),
      .act_per  (edge_act_e'(mode_q[B+2 +: 2])),
      .act_cmp  (edge_act_e'(mode_q[B +: 2])),
      .out_q    (lane_out[l])
    );
  end

  assign out_a = lane_out[0];
  assign out_b = lane_out[1];
endmodule

// File: rtl/tmr_wave_channel_chk.sv
module tmr_wave_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_fire,
  input logic             run_req,
  input logic             stop_req,
  input logic             run,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per,
  input logic             wave,
  input logic             out_a,
  input logic             out_b
);
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b && cnt == '0 && !run));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == per && !trig_fire) |=> cnt == '0);

  assert_trig_clear_R7: assert property (@(posedge clk) disable iff (rst)
    trig_fire |=> cnt == '0);

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (run_req && stop_req) |=> !run);

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !trig_fire) |=> $stable(cnt));

  assert_wave_low_R9: assert property (@(posedge clk) disable iff (rst)
    !wave |=> (!out_a && !out_b));
endmodule

bind tmr_wave_channel tmr_wave_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .trig_fire (trig_fire),
  .run_req   (run_req),
  .stop_req  (stop_req),
  .run       (run_q),
  .step      (step),
  .cnt       (cnt_q),
  .per       (per_q),
  .wave      (wave_on),
  .out_a     (out_a),
  .out_b     (out_b)
);

// File: tb/tmr_wave_channel_tb_top.sv
module tmr_wave_channel_tb_top;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0]  rd_data;
  logic slow_tick = 1'b0;
  logic out_a, out_b;

  always #10 clk = ~clk;

  tmr_wave_channel #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slow_tick(slow_tick),
    .out_a(out_a), .out_b(out_b)
  );

  // reference state
  logic [15:0] m_mode = '0;
  logic [15:0] m_ca = '0, m_cb = '0, m_per = '0, m_cnt = '0, m_rd = '0;
  logic [6:0]  m_pre = '0;
  logic m_run = 1'b0, m_a = 1'b0, m_b = 1'b0;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  function automatic logic act_apply(logic cur, logic [1:0] a);
    case (a)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic model_tick();
    logic [6:0] mask;
    if (m_mode[2:0] < 3'd4) begin
      mask = 7'((1 << (2 * m_mode[2:0] + 1)) - 1);
      return (m_pre & mask) == mask;
    end
    return slow_tick;
  endfunction

  function automatic logic lane_next(logic cur, logic trig, logic ev, logic [15:0] cmp, int base);
    logic [1:0] a;
    if (!m_mode[3]) return 1'b0;
    a = 2'd0;
    if (trig) a = m_mode[base+4 +: 2];
    else if (ev && m_cnt == m_per) a = m_mode[base+2 +: 2];
    else if (ev && m_cnt == cmp) a = m_mode[base +: 2];
    return act_apply(cur, a);
  endfunction

  function automatic logic [15:0] mk_mode(int sel, int wave, int ac, int ap, int at,
                                          int bc, int bp, int bt);
    return 16'(sel & 7) | 16'((wave & 1) << 3) | 16'((ac & 3) << 4) | 16'((ap & 3) << 6) |
           16'((at & 3) << 8) | 16'((bc & 3) << 10) | 16'((bp & 3) << 12) | 16'((bt & 3) << 14);
  endfunction

  task automatic model_step();
    logic trig, ev, na, nb;
    logic [15:0] nrd, ncnt;
    logic cmd;
    cmd  = wr_en && wr_addr == 3'd4;
    trig = cmd && wr_data[2];
    ev   = m_run && model_tick();
    case (rd_addr)
      3'd0: nrd = m_mode;
      3'd1: nrd = m_ca;
      3'd2: nrd = m_cb;
      3'd3: nrd = m_per;
      3'd4: nrd = m_cnt;
      default: nrd = '0;
    endcase
    na = lane_next(m_a, trig, ev, m_ca, 4);
    nb = lane_next(m_b, trig, ev, m_cb, 10);
    ncnt = m_cnt;
    if (trig) ncnt = '0;
    else if (ev) ncnt = (m_cnt == m_per) ? '0 : m_cnt + 16'd1;
    m_pre = trig ? '0 : m_pre + 7'd1;
    if (cmd && wr_data[1]) m_run = 1'b0;
    else if (cmd && wr_data[0]) m_run = 1'b1;
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_mode = wr_data;
        3'd1: m_ca = wr_data;
        3'd2: m_cb = wr_data;
        3'd3: m_per = wr_data;
        default: ;
      endcase
    end
    m_a = na; m_b = nb; m_cnt = ncnt; m_rd = nrd;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    check(tag, "out_a", 32'(out_a), 32'(m_a));
    check(tag, "out_b", 32'(out_b), 32'(m_b));
    check(tag, "rd_data", 32'(rd_data), 32'(m_rd));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_a", 32'(out_a), 0);
    check("R1", "out_b", 32'(out_b), 0);
    check("R1", "rd_data", 32'(rd_data), 0);
    rst = 1'b0;

    // R2: register write and read-back
    tag = "R2";
    wr(3'd1, 16'h1234);
    rd_addr = 3'd1; idle(1);
    check("R2", "cmp A readback", 32'(rd_data), 32'h1234);
    wr(3'd2, 16'h0bcd); wr(3'd3, 16'h0077); wr(3'd0, 16'h0008);
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); idle(2); end

    // R3: tick selection, division 32 then slow strobe
    tag = "R3";
    wr(3'd3, 16'hffff);
    wr(3'd0, mk_mode(2, 1, 0, 0, 0, 0, 0, 0));
    rd_addr = 3'd4;
    wr(3'd4, 16'h0005);
    idle(330);
    wr(3'd0, mk_mode(3, 1, 0, 0, 0, 0, 0, 0));
    idle(300);
    wr(3'd0, mk_mode(4, 1, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 60; i++) begin slow_tick = ($urandom % 3) == 0; step(); end
    wr(3'd0, mk_mode(7, 1, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 30; i++) begin slow_tick = i[0]; step(); end
    slow_tick = 1'b0;

    // R4: wrap on the period value
    tag = "R4";
    wr(3'd3, 16'd5);
    wr(3'd0, mk_mode(0, 1, 0, 0, 0, 0, 0, 0));
    wr(3'd4, 16'h0005);
    idle(40);

    // R5: every action code on both lanes including toggle
    tag = "R5";
    wr(3'd1, 16'd2); wr(3'd2, 16'd4);
    wr(3'd0, mk_mode(0, 1, 3, 3, 1, 1, 2, 2));
    wr(3'd4, 16'h0005);
    idle(60);

    // R6: compare equal to period, period event wins
    tag = "R6";
    wr(3'd1, 16'd5); wr(3'd2, 16'd5);
    wr(3'd0, mk_mode(0, 1, 1, 2, 2, 2, 0, 1));
    wr(3'd4, 16'h0004);
    idle(50);
    // trigger coincident with a would-be match: trigger wins
    wr(3'd0, mk_mode(1, 1, 3, 3, 0, 3, 3, 0));
    idle(9);
    wr(3'd4, 16'h0004);
    idle(20);

    // R7: trigger clears the counter and applies trigger actions
    tag = "R7";
    wr(3'd3, 16'd20);
    wr(3'd0, mk_mode(0, 1, 0, 0, 1, 0, 0, 2));
    idle(15);
    wr(3'd4, 16'h0004);
    idle(5);
    wr(3'd0, mk_mode(0, 1, 0, 0, 3, 0, 0, 3));
    wr(3'd4, 16'h0004);
    wr(3'd4, 16'h0004);
    idle(5);

    // R8: stop wins over start, stopped counter holds
    tag = "R8";
    wr(3'd4, 16'h0003);
    rd_addr = 3'd4; idle(2);
    c0 = rd_data;
    idle(40);
    check("R8", "held counter", 32'(rd_data), 32'(c0));
    wr(3'd4, 16'h0001);
    idle(20);
    wr(3'd4, 16'h0002);
    idle(20);

    // R9: waveform bit clear forces outputs low
    tag = "R9";
    wr(3'd0, mk_mode(0, 0, 1, 1, 1, 1, 1, 1));
    wr(3'd4, 16'h0005);
    idle(30);
    check("R9", "out_a low", 32'(out_a), 0);
    check("R9", "out_b low", 32'(out_b), 0);

    // R10: compare/period updates take effect without shadowing
    tag = "R10";
    wr(3'd3, 16'd12); wr(3'd1, 16'd3);
    wr(3'd0, mk_mode(0, 1, 2, 1, 2, 0, 0, 0));
    wr(3'd4, 16'h0005);
    idle(11);
    wr(3'd1, 16'd9);
    idle(7);
    wr(3'd3, 16'd4);
    idle(40);

    // R11: normal and inverted PWM, then static levels
    tag = "R11";
    wr(3'd3, 16'd9); wr(3'd1, 16'd3); wr(3'd2, 16'd6);
    wr(3'd0, mk_mode(0, 1, 2, 1, 2, 1, 2, 1));
    wr(3'd4, 16'h0005);
    idle(200);
    wr(3'd0, mk_mode(0, 1, 0, 0, 1, 0, 0, 2));
    wr(3'd4, 16'h0005);
    for (int i = 0; i < 60; i++) begin
      step();
      check("R11", "static A high", 32'(out_a), 1);
      check("R11", "static B low", 32'(out_b), 0);
    end

    // random mix of register, command and strobe activity
    tag = "R5";
    for (int i = 0; i < 15000; i++) begin
      int r;
      r = int'($urandom % 100);
      rd_addr = 3'($urandom % 6);
      slow_tick = ($urandom % 6) == 0;
      if (r < 3) begin
        wr_en = 1'b1; wr_addr = 3'd0;
        wr_data = 16'($urandom) | 16'((($urandom % 10) != 0) ? 8 : 0);
        if (($urandom % 3) != 0) wr_data[2:0] = 3'($urandom % 2);
      end else if (r < 7) begin
        wr_en = 1'b1; wr_addr = 3'(1 + $urandom % 2); wr_data = 16'($urandom % 24);
      end else if (r < 9) begin
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'($urandom % 24);
      end else if (r < 12) begin
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'($urandom % 8);
      end else begin
        wr_en = 1'b0;
      end
      step();
    end
    wr_en = 1'b0;
    finish_run();
  end
endmodule